// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer

This block is the command front end of a byte-wide, 256K x 8 NOR flash model. It watches bus write cycles framed by an active-low chip select and an active-low write strobe, and recognises the multi-write unlock sequences that start a program, a chip erase, a sector erase, identifier reads and a protection-unlock mode. It also handles the single-write commands for return-to-read, erase suspend and erase resume.

The block does not model the storage cells or the high-voltage timing. When a sequence completes, it issues a one-cycle start pulse to an external program/erase engine, together with the operation code, the address, the data byte and the decoded sector index. It then waits for the engine's done pulse. While it waits, it applies a state-dependent lock-out: a running program or chip erase ignores every write, and a running sector erase accepts only the suspend command. A mode output tells the read path what to return: array data, identifier bytes, busy status or the protect-unlock view. In identifier mode the block also supplies the identifier byte itself.

Top module: `flash_cmd_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in array mode (`mode`=0), with `eng_start` and `eng_hold` low, from any state.
- R2: The two unlock writes are AAh to address 555h and then 55h to address 2AAh. Only address bits 10:0 are compared, so bits 17:11 may hold any value.
- R3: Unlock followed by A0h at 555h arms a program. The next write pulses `eng_start` for one cycle with `eng_op`=0, `eng_addr`/`eng_data` equal to that write, and `mode`=2 (status) until `eng_done`.
- R4: Unlock, 80h at 555h, unlock, then 10h at 555h starts a chip erase (`eng_op`=1).
- R5: Unlock, 80h at 555h, unlock, then 30h at any address starts a sector erase (`eng_op`=2). `eng_sector` gives the sector holding that address. With the top-boot layout, 00000h-2FFFFh maps to address/64K (sectors 0-2), 30000h-37FFFh to 3, 38000h-39FFFh to 4, 3A000h-3BFFFh to 5, and 3C000h-3FFFFh to 6.
- R6: Unlock then 90h at 555h enters identifier mode (`mode`=1). There, `id_byte` is C2h when `addr[1:0]`=00, 36h (top boot) or 37h (bottom boot) when `addr[1:0]`=01, and 00h for any other value of `addr[1:0]`. Outside identifier mode `id_byte` is 00h.
- R7: A write of F0h to any address returns the block from identifier mode, protect-unlock mode or a partly entered sequence to array mode.
- R8: While a program runs, every write is ignored, including F0h, B0h and AAh/555h. `eng_done` returns the block to array mode.
- R9: While a sector erase runs, only B0h is accepted. B0h raises `eng_hold` and shows array mode. While suspended, 30h clears `eng_hold` and restores status mode, and any other write is ignored.
- R10: The erase sequence ending in 20h at 555h in place of 10h or 30h enters protect-unlock mode (`mode`=3) and starts no operation.
- R11: A write that does not match the expected step of a sequence returns the block to array mode and produces no start pulse.
- R12: The write address is captured when the write strobe falls and the data when it rises, so an address change between the two edges has no effect.
- R13: While a chip erase runs, every write is ignored, including B0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 18 | Byte address |
| din | input | 8 | Write data |
| eng_done | input | 1 | Engine completion pulse |
| mode | output | 2 | Read view: 0 array, 1 identifier, 2 status, 3 protect-unlock |
| id_byte | output | 8 | Identifier byte for the current address |
| eng_start | output | 1 | One-cycle operation start |
| eng_op | output | 2 | 0 program, 1 chip erase, 2 sector erase |
| eng_addr | output | 18 | Program or sector address |
| eng_data | output | 8 | Program data |
| eng_sector | output | 3 | Sector index of `eng_addr` |
| eng_hold | output | 1 | Erase suspended, engine must pause |

## Verification
The bench aims at the sector boundaries: it sweeps the first and last byte of every 4K page through a sector erase. A map with an off-by-one boundary would report the neighbouring sector for an edge address. It breaks each program and erase sequence at every step with a wrong write. A decoder that failed to reset its progress would start an operation on the following writes, or would stay in an intermediate mode. It drives unlock addresses with random upper bits and with a wrong low bit, which exposes comparisons that are too wide or too narrow. Finally, it sends every command class during each busy state. This exposes a lock-out that leaks F0h during a program, or accepts B0h during a chip erase.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int LOW_CMP_W = 11;

    localparam logic [LOW_CMP_W-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [LOW_CMP_W-1:0] KEY_ADDR_B = 11'h2AA;

    localparam logic [7:0] KEY_BYTE_A  = 8'hAA;
    localparam logic [7:0] KEY_BYTE_B  = 8'h55;
    localparam logic [7:0] OPC_PROGRAM = 8'hA0;
    localparam logic [7:0] OPC_ERASE   = 8'h80;
    localparam logic [7:0] OPC_IDENT   = 8'h90;
    localparam logic [7:0] OPC_WHOLE   = 8'h10;
    localparam logic [7:0] OPC_BLOCK   = 8'h30;
    localparam logic [7:0] OPC_GUARD   = 8'h20;
    localparam logic [7:0] OPC_PAUSE   = 8'hB0;
    localparam logic [7:0] OPC_ABORT   = 8'hF0;

    localparam logic [7:0] MAKER_CODE   = 8'hC2;
    localparam logic [7:0] PART_TOP     = 8'h36;
    localparam logic [7:0] PART_BOTTOM  = 8'h37;

    typedef enum logic [1:0] {
        VIEW_ARRAY  = 2'd0,
        VIEW_IDENT  = 2'd1,
        VIEW_STATUS = 2'd2,
        VIEW_GUARD  = 2'd3
    } view_e;

    typedef enum logic [1:0] {
        JOB_PROGRAM = 2'd0,
        JOB_WHOLE   = 2'd1,
        JOB_BLOCK   = 2'd2
    } job_e;

    typedef enum logic [3:0] {
        ST_READ,
        ST_KEY1,
        ST_KEY2,
        ST_PGM_ARM,
        ST_ERS_SETUP,
        ST_EKEY1,
        ST_EKEY2,
        ST_IDENT,
        ST_GUARD,
        ST_RUN_PGM,
        ST_RUN_WHOLE,
        ST_RUN_BLOCK,
        ST_PAUSED
    } seq_e;

    typedef struct packed {
        logic [17:0] a;
        logic [7:0]  d;
    } bus_wr_t;

    function automatic logic hit(input logic [LOW_CMP_W-1:0] a_lo,
                                 input logic [7:0] d,
                                 input logic [LOW_CMP_W-1:0] want_a,
                                 input logic [7:0] want_d);
        return (a_lo == want_a) && (d == want_d);
    endfunction

endpackage

// File: rtl/flash_wr_capture.sv
module flash_wr_capture
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    logic              we_q;
    logic [ADDR_W-1:0] a_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q   <= 1'b1;
            a_hold <= '0;
        end else begin
            we_q <= we_n;
            if (!ce_n && we_q && !we_n)
                a_hold <= addr;
        end
    end

    // commit on the strobe's rising edge while selected
    assign wr_fire = !ce_n && !we_q && we_n;
    assign wr_addr = a_hold;
    assign wr_data = din;

endmodule

// File: rtl/flash_sector_map.sv
module flash_sector_map #(
    parameter int ADDR_W   = 18,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [ADDR_W-1:0] a,
    output logic [2:0]        sector
);
    localparam int HI = ADDR_W - 1;

    generate
        if (TOP_BOOT) begin : g_top
            always_comb begin
                if (a[HI:HI-1] != 2'b11)  sector = {1'b0, a[HI:HI-1]};
                else if (!a[HI-2])        sector = 3'd3;
                else if (a[HI-3])         sector = 3'd6;
                else if (a[HI-4])         sector = 3'd5;
                else                      sector = 3'd4;
            end
        end else begin : g_bottom
            always_comb begin
                if (a[HI:HI-1] != 2'b00)  sector = 3'd3 + {1'b0, a[HI:HI-1]};
                else if (a[HI-2])         sector = 3'd3;
                else if (!a[HI-3])        sector = 3'd0;
                else if (a[HI-4])         sector = 3'd2;
                else                      sector = 3'd1;
            end
        end
    endgenerate

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [2:0]        wr_sector,
    input  logic              eng_done,
    output view_e             view,
    output logic              eng_start,
    output job_e              eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [7:0]        eng_data,
    output logic [2:0]        eng_sector,
    output logic              eng_hold
);
    seq_e st, st_nx;
    logic go;
    job_e go_job;
    logic [LOW_CMP_W-1:0] lo;
    logic key_a, key_b, at_a;

    assign lo    = wr_addr[LOW_CMP_W-1:0];
    assign key_a = hit(lo, wr_data, KEY_ADDR_A, KEY_BYTE_A);
    assign key_b = hit(lo, wr_data, KEY_ADDR_B, KEY_BYTE_B);
    assign at_a  = (lo == KEY_ADDR_A);

    always_comb begin
        st_nx  = st;
        go     = 1'b0;
        go_job = JOB_PROGRAM;
        if (eng_done && (st == ST_RUN_PGM || st == ST_RUN_WHOLE || st == ST_RUN_BLOCK)) begin
            st_nx = ST_READ;
        end else if (wr_fire) begin
            unique case (st)
                ST_READ, ST_IDENT, ST_GUARD:
                    st_nx = key_a ? ST_KEY1 : ST_READ;
                ST_KEY1:      st_nx = key_b ? ST_KEY2 : ST_READ;
                ST_KEY2: begin
                    if (at_a && wr_data == OPC_PROGRAM)    st_nx = ST_PGM_ARM;
                    else if (at_a && wr_data == OPC_ERASE) st_nx = ST_ERS_SETUP;
                    else if (at_a && wr_data == OPC_IDENT) st_nx = ST_IDENT;
                    else                                   st_nx = ST_READ;
                end
                ST_PGM_ARM: begin
                    st_nx = ST_RUN_PGM;
                    go    = 1'b1;
                end
                ST_ERS_SETUP: st_nx = key_a ? ST_EKEY1 : ST_READ;
                ST_EKEY1:     st_nx = key_b ? ST_EKEY2 : ST_READ;
                ST_EKEY2: begin
                    if (at_a && wr_data == OPC_WHOLE) begin
                        st_nx = ST_RUN_WHOLE; go = 1'b1; go_job = JOB_WHOLE;
                    end else if (wr_data == OPC_BLOCK) begin
                        st_nx = ST_RUN_BLOCK; go = 1'b1; go_job = JOB_BLOCK;
                    end else if (at_a && wr_data == OPC_GUARD) begin
                        st_nx = ST_GUARD;
                    end else begin
                        st_nx = ST_READ;
                    end
                end
                ST_RUN_BLOCK: if (wr_data == OPC_PAUSE) st_nx = ST_PAUSED;
                ST_PAUSED:    if (wr_data == OPC_BLOCK) st_nx = ST_RUN_BLOCK;
                default:      st_nx = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_READ;
            eng_start  <= 1'b0;
            eng_op     <= JOB_PROGRAM;
            eng_addr   <= '0;
            eng_data   <= '0;
            eng_sector <= '0;
        end else begin
            st        <= st_nx;
            eng_start <= go;
            if (go) begin
                eng_op     <= go_job;
                eng_addr   <= wr_addr;
                eng_data   <= wr_data;
                eng_sector <= wr_sector;
            end
        end
    end

    always_comb begin
        unique case (st)
            ST_IDENT:                               view = VIEW_IDENT;
            ST_GUARD:                               view = VIEW_GUARD;
            ST_RUN_PGM, ST_RUN_WHOLE, ST_RUN_BLOCK: view = VIEW_STATUS;
            default:                                view = VIEW_ARRAY;
        endcase
    end
    assign eng_hold = (st == ST_PAUSED);

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (st == ST_READ && !eng_start));
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);
    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> view == VIEW_STATUS);
    assert_pgm_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN_PGM && !eng_done) |=> st == ST_RUN_PGM);
    assert_whole_locked_R13: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN_WHOLE && !eng_done) |=> st == ST_RUN_WHOLE);
    assert_pause_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_hold) |-> ($past(wr_fire) && $past(wr_data) == OPC_PAUSE));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              eng_done,
    output logic [1:0]        mode,
    output logic [7:0]        id_byte,
    output logic              eng_start,
    output logic [1:0]        eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [7:0]        eng_data,
    output logic [2:0]        eng_sector,
    output logic              eng_hold
);
    localparam logic [7:0] PART_CODE = TOP_BOOT ? PART_TOP : PART_BOTTOM;

    logic              wr_fire;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [2:0]        wr_sector;
    view_e             view;
    job_e              job;

    flash_wr_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    flash_sector_map #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_map (
        .a(wr_addr), .sector(wr_sector)
    );

    flash_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_sector(wr_sector), .eng_done(eng_done),
        .view(view), .eng_start(eng_start), .eng_op(job), .eng_addr(eng_addr),
        .eng_data(eng_data), .eng_sector(eng_sector), .eng_hold(eng_hold)
    );

    assign mode   = view;
    assign eng_op = job;

    always_comb begin
        id_byte = 8'h00;
        if (view == VIEW_IDENT) begin
            if (addr[1:0] == 2'b00)      id_byte = MAKER_CODE;
            else if (addr[1:0] == 2'b01) id_byte = PART_CODE;
        end
    end

    assert_hold_only_paused_R9: assert property (@(posedge clk) disable iff (rst)
        eng_hold |-> !eng_start);

endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  din = '0;
    logic        eng_done = 1'b0;
    logic [1:0]  mode;
    logic [7:0]  id_byte;
    logic        eng_start;
    logic [1:0]  eng_op;
    logic [17:0] eng_addr;
    logic [7:0]  eng_data;
    logic [2:0]  eng_sector;
    logic        eng_hold;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
        .eng_done(eng_done), .mode(mode), .id_byte(id_byte),
        .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr),
        .eng_data(eng_data), .eng_sector(eng_sector), .eng_hold(eng_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // address driven at strobe fall, optionally changed before strobe rise
    task automatic wr2(logic [17:0] a_fall, logic [17:0] a_rise, logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a_fall;
        @(negedge clk); we_n = 1'b1; addr = a_rise; din = d;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic wr(logic [17:0] a, logic [7:0] d);
        wr2(a, a, d);
    endtask

    task automatic unlock(logic [17:0] up);
        wr(up | 18'h555, 8'hAA);
        wr(up | 18'h2AA, 8'h55);
    endtask

    task automatic finish_op();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic erase_head();
        unlock(0); wr(18'h555, 8'h80); unlock(0);
    endtask

    function automatic int exp_sector(int a);
        if (a < 'h30000) return a >> 16;
        if (a < 'h38000) return 3;
        if (a < 'h3A000) return 4;
        if (a < 'h3C000) return 5;
        return 6;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int started;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 start", eng_start, 0);
        check("R1 hold", eng_hold, 0);

        // R3 basic program
        unlock(0); wr(18'h555, 8'hA0); wr(18'h12345, 8'h5A);
        check("R3 start", eng_start, 1);
        check("R3 op", eng_op, 0);
        check("R3 addr", eng_addr, 18'h12345);
        check("R3 data", eng_data, 8'h5A);
        check("R3 mode", mode, 2);
        @(negedge clk);
        check("R3 pulse", eng_start, 0);
        // R8 lockout during program
        wr(18'h0, 8'hF0); wr(18'h0, 8'hB0); unlock(0);
        check("R8 still busy", mode, 2);
        check("R8 hold", eng_hold, 0);
        finish_op();
        check("R8 done", mode, 0);

        // R2 unlock with upper bits swept
        for (int u = 0; u < 128; u += 9) begin
            unlock(18'(u << 11)); wr(18'(u << 11) | 18'h555, 8'hA0);
            wr(18'(u * 5), 8'(u));
            check("R2 start", eng_start, 1);
            check("R2 data", eng_data, 8'(u));
            finish_op();
        end
        // R2 wrong low bit: 554h
        wr(18'h554, 8'hAA); wr(18'h2AA, 8'h55); wr(18'h555, 8'hA0);
        check("R2 narrow", mode, 0);
        wr(18'h100, 8'h11);
        check("R2 no start", eng_start, 0);

        // R12 address latched at fall
        unlock(0); wr(18'h555, 8'hA0); wr2(18'h2BEEF, 18'h01234, 8'h77);
        check("R12 addr", eng_addr, 18'h2BEEF);
        check("R12 data", eng_data, 8'h77);
        finish_op();

        // R4 chip erase and R13 lockout
        erase_head(); wr(18'h555, 8'h10);
        check("R4 start", eng_start, 1);
        check("R4 op", eng_op, 1);
        wr(18'h0, 8'hB0); wr(18'h0, 8'hF0);
        check("R13 busy", mode, 2);
        check("R13 hold", eng_hold, 0);
        finish_op();
        check("R4 done", mode, 0);

        // R5 sector sweep over page edges
        for (int p = 0; p < 64; p++) begin
            for (int e = 0; e < 2; e++) begin
                int a = p * 'h1000 + e * 'hFFF;
                erase_head(); wr(18'(a), 8'h30);
                check("R5 op", eng_op, 2);
                check("R5 sector", eng_sector, exp_sector(a));
                finish_op();
            end
        end

        // R9 suspend / resume
        erase_head(); wr(18'h21000, 8'h30);
        wr(18'h0, 8'hF0);
        check("R9 ignore", mode, 2);
        wr(18'h0, 8'hB0);
        check("R9 hold", eng_hold, 1);
        check("R9 array", mode, 0);
        wr(18'h0, 8'hF0); unlock(0);
        check("R9 stay paused", eng_hold, 1);
        wr(18'h0, 8'h30);
        check("R9 resume", eng_hold, 0);
        check("R9 status", mode, 2);
        finish_op();
        check("R9 done", mode, 0);

        // R6 identifier reads
        unlock(0); wr(18'h555, 8'h90);
        check("R6 mode", mode, 1);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); addr = 18'(k * 'h1234 + k);
            #1;
            check("R6 id", id_byte, (addr[1:0] == 0) ? 8'hC2 : (addr[1:0] == 1) ? 8'h36 : 8'h00);
        end
        // R7 abort
        wr(18'h3FFFF, 8'hF0);
        check("R7 exit id", mode, 0);
        addr = 18'h0; #1;
        check("R6 id off", id_byte, 0);

        // R10 protect unlock
        erase_head(); wr(18'h555, 8'h20);
        check("R10 mode", mode, 3);
        check("R10 no start", eng_start, 0);
        wr(18'h0, 8'hF0);
        check("R7 exit guard", mode, 0);

        // R11 break program sequence at each step
        for (int s = 0; s < 3; s++) begin
            if (s >= 1) wr(18'h555, 8'hAA);
            if (s >= 2) wr(18'h2AA, 8'h55);
            wr(18'h555, 8'h12);
            check("R11 pgm", mode, 0);
            check("R11 pgm start", eng_start, 0);
        end
        // R11 break erase sequence at each step
        for (int s = 0; s < 3; s++) begin
            unlock(0); wr(18'h555, 8'h80);
            if (s >= 1) wr(18'h555, 8'hAA);
            if (s >= 2) wr(18'h2AA, 8'h55);
            wr(18'h2AA, 8'h44);
            check("R11 ers", mode, 0);
            check("R11 ers start", eng_start, 0);
            wr(18'h555, 8'h30);
            check("R11 no late start", eng_start, 0);
        end

        // R7 abort mid-sequence, R1 reset from id mode
        unlock(0); wr(18'h0, 8'hF0);
        wr(18'h555, 8'hA0);
        check("R7 mid", mode, 0);
        unlock(0); wr(18'h555, 8'h90);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset id", mode, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule